// File: doc/BRIEF.md
# Next-PC and Instruction Kill Control

This block is the combinational steering logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it chooses where the next fetch address comes from: the sequential address, an absolute jump target, a register-indirect target, or a conditional branch target. It also decides whether the decode-stage and execute-stage instruction registers take their normal input or an all-zero nop, which is how it removes wrong-path instructions. It gives a hold indication for the fetch address and the decode register while the pipeline is interlocked.

Conditional branches are resolved in execute, using the zero flag of the execute-stage operand. Jumps are recognised in decode. When both want to redirect in the same cycle, the older instruction in execute wins. A jump therefore costs one bubble and a taken branch costs two. The target arithmetic, the register file, the ALU and the stage registers themselves are outside this block. The block only produces the select and hold signals that those registers and muxes use.

Top module: `pc_kill_ctrl`

## Requirements
- R1: Opcodes are the 6-bit field of the instruction word, bits 31 to 26. The branch-if-zero opcode is 4 and the branch-if-nonzero opcode is 5. Either one in execute is taken when its condition holds on zero_e_i. A taken branch drives pc_sel_o to 3 (branch target).
- R2: A branch in execute whose condition fails has no effect on the outputs. They are the same as for a non-control opcode in execute.
- R3: With no taken branch in execute, pc_sel_o is 1 (absolute target) for the absolute jump opcodes 2 and 3 in decode. It is 2 (register-indirect target) for the indirect jump opcodes 6 and 7 in decode. For any other decode opcode, including the all-zero nop, it is 0 (sequential).
- R4: A taken branch in execute outranks any jump in decode. pc_sel_o is then 3, whatever the decode opcode is.
- R5: ird_sel_o is 1 (load nop into decode) when the branch in execute is taken or when decode holds any of the four jump opcodes. Otherwise it is 0 (load the fetched word).
- R6: ire_sel_o is 1 (load nop into execute) when the branch in execute is taken or when stall_i is high. Otherwise it is 0 (take the decode instruction).
- R7: fetch_hold_o is 1 exactly when stall_i is high and no branch in execute is taken. A taken branch overrides the stall.
- R8: In a pipeline built on these selects, a jump is followed into execute by one nop before its target. A taken branch is followed by two nops. A branch that is not taken is followed by its sequential successors with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_d_i | input | 6 | Opcode field of the decode-stage instruction |
| opc_e_i | input | 6 | Opcode field of the execute-stage instruction |
| zero_e_i | input | 1 | Execute-stage operand equals zero |
| stall_i | input | 1 | Interlock request from decode |
| pc_sel_o | output | 2 | Next fetch address source: 0 sequential, 1 absolute, 2 indirect, 3 branch |
| ird_sel_o | output | 1 | Decode register source: 1 nop, 0 fetched word |
| ire_sel_o | output | 1 | Execute register source: 1 nop, 0 decode instruction |
| fetch_hold_o | output | 1 | Hold the fetch address and the decode register this cycle |

## Verification
The assertions treat every combination of opcode, zero flag and stall as legal. They do not assume that an interlock and a jump never meet in decode. They are evaluated on settled combinational values, so the bench changes inputs only between samples and never reads the outputs in the same step that it drives them. The directed stimulus includes deliberately conflicting cases, such as a stall beside a taken branch and a jump behind a branch. The pipeline scenarios take their opcodes only from bench-modelled stage registers, which keeps execute and decode consistent with a real instruction stream.

// File: rtl/pc_kill_pkg.sv
package pc_kill_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned NUM_STG = 2;
  localparam int unsigned STG_D   = 0;
  localparam int unsigned STG_E   = 1;

  localparam logic [OPC_W-1:0] OPC_J    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL  = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQZ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNEZ = 6'd5;
  localparam logic [OPC_W-1:0] OPC_JR   = 6'd6;
  localparam logic [OPC_W-1:0] OPC_JALR = 6'd7;

  typedef enum logic [2:0] {
    CLS_SEQ,
    CLS_JABS,
    CLS_JIND,
    CLS_BEQZ,
    CLS_BNEZ
  } ctl_cls_e;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_JABS = 2'd1,
    PC_JIND = 2'd2,
    PC_BR   = 2'd3
  } pc_sel_e;

endpackage

// File: rtl/pc_kill_opc_class.sv
module pc_kill_opc_class
  import pc_kill_pkg::*;
#(
  parameter int unsigned OpcW = OPC_W
) (
  input  logic [OpcW-1:0] opc_i,
  output ctl_cls_e        cls_o
);

  always_comb begin
    cls_o = CLS_SEQ;
    if (opc_i == OpcW'(OPC_J) || opc_i == OpcW'(OPC_JAL))        cls_o = CLS_JABS;
    else if (opc_i == OpcW'(OPC_JR) || opc_i == OpcW'(OPC_JALR)) cls_o = CLS_JIND;
    else if (opc_i == OpcW'(OPC_BEQZ))                            cls_o = CLS_BEQZ;
    else if (opc_i == OpcW'(OPC_BNEZ))                            cls_o = CLS_BNEZ;
  end

endmodule

// File: rtl/pc_kill_br_resolve.sv
module pc_kill_br_resolve
  import pc_kill_pkg::*;
(
  input  ctl_cls_e cls_i,
  input  logic     zero_i,
  output logic     taken_o
);

  always_comb begin
    unique case (cls_i)
      CLS_BEQZ: taken_o = zero_i;
      CLS_BNEZ: taken_o = ~zero_i;
      default:  taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pc_kill_redirect_arb.sv
module pc_kill_redirect_arb
  import pc_kill_pkg::*;
(
  input  logic     br_taken_i,
  input  ctl_cls_e cls_d_i,
  input  logic     stall_i,
  output pc_sel_e  pc_sel_o,
  output logic     kill_d_o,
  output logic     kill_e_o,
  output logic     hold_o
);

  logic jump_d;

  assign jump_d = (cls_d_i == CLS_JABS) || (cls_d_i == CLS_JIND);

  // older (execute) redirect first
  always_comb begin
    if (br_taken_i)                pc_sel_o = PC_BR;
    else if (cls_d_i == CLS_JABS)  pc_sel_o = PC_JABS;
    else if (cls_d_i == CLS_JIND)  pc_sel_o = PC_JIND;
    else                           pc_sel_o = PC_SEQ;
  end

  assign kill_d_o = br_taken_i | jump_d;
  assign kill_e_o = br_taken_i | stall_i;
  // decode slot is wrong-path when a branch is taken: its stall is void
  assign hold_o   = stall_i & ~br_taken_i;

endmodule

// File: rtl/pc_kill_ctrl.sv
module pc_kill_ctrl
  import pc_kill_pkg::*;
#(
  parameter int unsigned OpcW = OPC_W
) (
  input  logic [OpcW-1:0] opc_d_i,
  input  logic [OpcW-1:0] opc_e_i,
  input  logic            zero_e_i,
  input  logic            stall_i,
  output logic [1:0]      pc_sel_o,
  output logic            ird_sel_o,
  output logic            ire_sel_o,
  output logic            fetch_hold_o
);

  logic [OpcW-1:0] opc_stg [NUM_STG];
  ctl_cls_e        cls_stg [NUM_STG];
  logic            br_taken;
  pc_sel_e         pc_sel;

  assign opc_stg[STG_D] = opc_d_i;
  assign opc_stg[STG_E] = opc_e_i;

  for (genvar g = 0; g < NUM_STG; g++) begin : g_cls
    pc_kill_opc_class #(.OpcW(OpcW)) i_cls (
      .opc_i (opc_stg[g]),
      .cls_o (cls_stg[g])
    );
  end

  pc_kill_br_resolve i_br (
    .cls_i   (cls_stg[STG_E]),
    .zero_i  (zero_e_i),
    .taken_o (br_taken)
  );

  pc_kill_redirect_arb i_arb (
    .br_taken_i (br_taken),
    .cls_d_i    (cls_stg[STG_D]),
    .stall_i    (stall_i),
    .pc_sel_o   (pc_sel),
    .kill_d_o   (ird_sel_o),
    .kill_e_o   (ire_sel_o),
    .hold_o     (fetch_hold_o)
  );

  assign pc_sel_o = pc_sel;

endmodule

// File: rtl/pc_kill_ctrl_chk.sv
module pc_kill_ctrl_chk #(
  parameter int unsigned OpcW = 6
) (
  input logic [OpcW-1:0] opc_d_i,
  input logic [OpcW-1:0] opc_e_i,
  input logic            zero_e_i,
  input logic            stall_i,
  input logic [1:0]      pc_sel_o,
  input logic            ird_sel_o,
  input logic            ire_sel_o,
  input logic            fetch_hold_o
);

  logic taken;

  always_comb begin
    taken = ((opc_e_i == OpcW'(4)) && zero_e_i) || ((opc_e_i == OpcW'(5)) && !zero_e_i);

    a_r1_taken_selects_br: assert (!taken || pc_sel_o == 2'd3)
      else $error("R1: taken branch without branch select");
    a_r4_br_kills_both: assert (pc_sel_o != 2'd3 || (ird_sel_o && ire_sel_o))
      else $error("R4: branch redirect without double kill");
    a_r3_jump_kills_decode: assert (!(pc_sel_o == 2'd1 || pc_sel_o == 2'd2) || ird_sel_o)
      else $error("R3: jump redirect without decode kill");
    a_r5_no_kill_is_seq: assert (ird_sel_o || pc_sel_o == 2'd0)
      else $error("R5: redirect while decode keeps fetched word");
    a_r6_stall_kills_exec: assert (!stall_i || ire_sel_o)
      else $error("R6: stall without execute bubble");
    a_r7_hold_not_on_br: assert (!fetch_hold_o || (stall_i && pc_sel_o != 2'd3))
      else $error("R7: hold during branch redirect or without stall");
  end

endmodule

bind pc_kill_ctrl pc_kill_ctrl_chk #(.OpcW(OpcW)) i_chk (
  .opc_d_i      (opc_d_i),
  .opc_e_i      (opc_e_i),
  .zero_e_i     (zero_e_i),
  .stall_i      (stall_i),
  .pc_sel_o     (pc_sel_o),
  .ird_sel_o    (ird_sel_o),
  .ire_sel_o    (ire_sel_o),
  .fetch_hold_o (fetch_hold_o)
);

// File: tb/test_pc_kill_ctrl.sv
module test_pc_kill_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] O_ADD = 6'd12;
  localparam logic [5:0] O_J = 6'd2, O_JAL = 6'd3, O_BEQZ = 6'd4, O_BNEZ = 6'd5;
  localparam logic [5:0] O_JR = 6'd6, O_JALR = 6'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;

  logic       pipe_mode = 1'b0;
  logic [5:0] drv_opc_d = '0, drv_opc_e = '0;
  logic       drv_zero = 1'b0, drv_stall = 1'b0;

  logic [5:0]  opc_d, opc_e;
  logic [1:0]  pc_sel;
  logic        ird_sel, ire_sel, hold;

  logic [31:0] imem [16];
  logic [31:0] ir_d, ir_e;
  logic [3:0]  pc;
  logic [31:0] trace [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign opc_d = pipe_mode ? ir_d[31:26] : drv_opc_d;
  assign opc_e = pipe_mode ? ir_e[31:26] : drv_opc_e;

  pc_kill_ctrl i_pc_kill_ctrl (
    .opc_d_i      (opc_d),
    .opc_e_i      (opc_e),
    .zero_e_i     (drv_zero),
    .stall_i      (drv_stall),
    .pc_sel_o     (pc_sel),
    .ird_sel_o    (ird_sel),
    .ire_sel_o    (ire_sel),
    .fetch_hold_o (hold)
  );

  // bench-side pipeline registers steered by the block's selects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ir_d <= '0; ir_e <= '0;
    end else begin
      ir_e <= ire_sel ? 32'd0 : ir_d;
      if (!hold) begin
        ir_d <= ird_sel ? 32'd0 : imem[pc];
        case (pc_sel)
          2'd1, 2'd2: pc <= ir_d[3:0];
          2'd3:       pc <= ir_e[3:0];
          default:    pc <= pc + 4'd1;
        endcase
      end
    end
  end

  function automatic logic [31:0] w_add(int id);
    return {O_ADD, 26'(id + 100)};
  endfunction

  function automatic logic [31:0] w_ctl(logic [5:0] op, logic [3:0] tgt);
    return {op, 22'd0, tgt};
  endfunction

  // expected {pc_sel, kill_d, kill_e, hold} from the requirements
  function automatic logic [4:0] model(logic [5:0] od, logic [5:0] oe, logic z, logic st);
    logic tk, jd;
    logic [1:0] ps;
    tk = (oe == O_BEQZ && z) || (oe == O_BNEZ && !z);
    jd = (od == O_J || od == O_JAL || od == O_JR || od == O_JALR);
    if (tk) ps = 2'd3;
    else if (od == O_J || od == O_JAL) ps = 2'd1;
    else if (od == O_JR || od == O_JALR) ps = 2'd2;
    else ps = 2'd0;
    return {ps, tk | jd, tk | st, st & ~tk};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] od, logic [5:0] oe, logic z, logic st, string req);
    @(negedge clk);
    drv_opc_d = od; drv_opc_e = oe; drv_zero = z; drv_stall = st;
    #1;
    chk(req, {27'd0, pc_sel, ird_sel, ire_sel, hold}, {27'd0, model(od, oe, z, st)});
  endtask

  task automatic t_reset;
    pipe_mode = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R3 reset idle", {27'd0, pc_sel, ird_sel, ire_sel, hold}, 32'd0);
    pipe_mode = 1'b0;
  endtask

  task automatic t_taken_branch;
    drive(O_ADD, O_BEQZ, 1'b1, 1'b0, "R1 beqz taken");
    chk("R1 beqz sel", {30'd0, pc_sel}, 32'd3);
    drive(O_ADD, O_BNEZ, 1'b0, 1'b0, "R1 bnez taken");
  endtask

  task automatic t_untaken;
    drive(O_ADD, O_BEQZ, 1'b0, 1'b0, "R2 beqz not taken");
    drive(O_J,   O_BNEZ, 1'b1, 1'b0, "R2 bnez not taken, jump in decode");
    chk("R2 sel from decode", {30'd0, pc_sel}, 32'd1);
  endtask

  task automatic t_jumps;
    drive(O_J,    O_ADD, 1'b0, 1'b0, "R3 j");
    drive(O_JAL,  O_ADD, 1'b1, 1'b0, "R3 jal");
    drive(O_JR,   O_ADD, 1'b0, 1'b0, "R3 jr");
    chk("R3 jr sel", {30'd0, pc_sel}, 32'd2);
    drive(O_JALR, 6'd0,  1'b0, 1'b0, "R3 jalr");
    drive(6'd0,   6'd0,  1'b1, 1'b0, "R3 nop sequential");
  endtask

  task automatic t_priority;
    drive(O_JR, O_BEQZ, 1'b1, 1'b0, "R4 branch over jr");
    chk("R4 branch wins", {30'd0, pc_sel}, 32'd3);
    drive(O_J, O_BNEZ, 1'b0, 1'b0, "R4 branch over j");
  endtask

  task automatic t_kills;
    for (int op = 0; op < 16; op++) begin
      drive(6'(op), O_ADD, 1'b0, 1'b0, "R5 decode kill sweep");
    end
    drive(O_ADD, O_ADD, 1'b0, 1'b1, "R6 stall bubble");
    chk("R6 ire nop", {31'd0, ire_sel}, 32'd1);
    drive(O_ADD, O_ADD, 1'b0, 1'b0, "R6 no stall");
  endtask

  task automatic t_hold;
    drive(O_ADD, O_ADD, 1'b0, 1'b1, "R7 hold on stall");
    chk("R7 hold set", {31'd0, hold}, 32'd1);
    drive(O_ADD, O_BEQZ, 1'b1, 1'b1, "R7 branch overrides stall");
    chk("R7 hold clear", {31'd0, hold}, 32'd0);
    drive(O_JR, O_BNEZ, 1'b1, 1'b1, "R7 stall with untaken branch");
  endtask

  task automatic run_prog(logic z);
    pipe_mode = 1'b1;
    drv_stall = 1'b0;
    drv_zero  = z;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      trace[i] = ir_e;
    end
    pipe_mode = 1'b0;
  endtask

  task automatic load_adds;
    for (int i = 0; i < 16; i++) imem[i] = w_add(i);
  endtask

  task automatic t_pipe_jump;
    load_adds();
    imem[1] = w_ctl(O_J, 4'd10);
    run_prog(1'b0);
    chk("R8 jump: I0 in EX", trace[1], w_add(0));
    chk("R8 jump: J in EX", trace[2], imem[1]);
    chk("R8 jump: one bubble", trace[3], 32'd0);
    chk("R8 jump: target next", trace[4], w_add(10));
  endtask

  task automatic t_pipe_branch;
    load_adds();
    imem[1] = w_ctl(O_BEQZ, 4'd12);
    run_prog(1'b1);
    chk("R8 branch: in EX", trace[2], imem[1]);
    chk("R8 branch: bubble 1", trace[3], 32'd0);
    chk("R8 branch: bubble 2", trace[4], 32'd0);
    chk("R8 branch: target", trace[5], w_add(12));
  endtask

  task automatic t_pipe_untaken;
    load_adds();
    imem[1] = w_ctl(O_BEQZ, 4'd12);
    run_prog(1'b0);
    chk("R8 untaken: successor", trace[3], w_add(2));
    chk("R8 untaken: next", trace[4], w_add(3));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    load_adds();
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_taken_branch();
    t_untaken();
    t_jumps();
    t_priority();
    t_kills();
    t_hold();
    t_pipe_jump();
    t_pipe_branch();
    t_pipe_untaken();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule